// File: doc/BRIEF.md
# I2C Multi-Master Byte Transfer Engine

This block is the bit-level data path of a multi-master I2C controller. It moves one byte per command. A write byte goes out on SDA most significant bit first, across eight clock pulses. A read byte is sampled in over eight pulses. The ninth pulse carries the acknowledge. The block also produces the START, repeated START and STOP conditions on SDA. It drives SDA only as an open-drain pull-down enable, and it reads the resolved bus level back on a sampled input.

SCL is not generated here. An external SCL timing unit gives two one-cycle strobes in each bit period. `stb_low` falls in the middle of the SCL low phase, and the engine may change SDA only then. `stb_high` falls in the middle of the SCL high phase, and SDA is sampled then. The engine tells the timing unit when it needs pulses through `scl_req`.

On every bit it transmits, the engine compares the bus level with the level it released. When it loses arbitration, it lets go of SDA at once and returns to idle without a STOP. It records the loss in a sticky flag that software clears. A bus monitor follows START and STOP conditions from any master, and a START command is held back until the bus is free.

Top module: `i2c_byte_engine`

## Requirements
- R1: While `rst_n` is low, and on the cycle after it rises, `sda_drive_low`, `busy`, `done`, `arb_lost` and `bus_busy` are 0.
- R2: A write command (`cmd_op`=3) drives the `DATA_W` bits of `cmd_data` on SDA MSB first, one bit per pulse; a 1 is sent by releasing (`sda_drive_low`=0). `sda_drive_low` changes only in the cycle after a `stb_low` or `stb_high` strobe.
- R3: After a write byte, SDA is released during the ninth pulse, and `ack_rcvd` reports 1 if SDA was sampled low at that pulse's `stb_high` and 0 otherwise; it is valid from the `done` pulse.
- R4: A read command (`cmd_op`=4) keeps SDA released for the eight data pulses, samples SDA at each `stb_high` MSB first, and presents the byte on `rx_data` from the `done` pulse.
- R5: During the ninth pulse of a read, `sda_drive_low` is 1 when `cmd_ack` was 1 (acknowledge) and 0 when it was 0 (no acknowledge on the final byte).
- R6: A START command (`cmd_op`=0) waits while `bus_busy` is 1; once the bus is free, it pulls SDA low in the cycle after a `stb_high` and pulses `done`.
- R7: A STOP command (`cmd_op`=1) pulls SDA low after a `stb_low`, releases it after the following `stb_high`, and `done` pulses; `bus_busy` then falls.
- R8: A repeated START command (`cmd_op`=2) releases SDA after a `stb_low` and pulls it low after the following `stb_high`; `bus_busy` stays 1.
- R9: If SDA reads low at `stb_high` on a write bit that the engine released, then in the next cycle `sda_drive_low` is 0, `arb_lost` is 1, `done` pulses and `busy` is 0. The engine drives SDA no further in that byte.
- R10: `arb_lost` stays 1 until `arb_clr` is asserted and then reads 0.
- R11: `bus_busy` becomes 1 the cycle after SDA falls while SCL is high, and 0 the cycle after SDA rises while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL bus level |
| sda_in | input | 1 | Sampled SDA bus level |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| stb_low | input | 1 | Strobe in the SCL low phase |
| stb_high | input | 1 | Strobe in the SCL high phase |
| scl_req | output | 1 | Engine needs SCL pulses |
| cmd_valid | input | 1 | Command accepted when `busy` is 0 |
| cmd_op | input | 3 | 0 START, 1 STOP, 2 repeated START, 3 write, 4 read |
| cmd_data | input | DATA_W | Byte to write |
| cmd_ack | input | 1 | Read: 1 acknowledges the byte, 0 withholds it |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at the end of a command |
| rx_data | output | DATA_W | Byte sampled from the bus |
| ack_rcvd | output | 1 | Acknowledge seen after the last write |
| arb_lost | output | 1 | Sticky arbitration-loss flag |
| arb_clr | input | 1 | Clears `arb_lost` |
| bus_busy | output | 1 | Bus is held by some master |

## Verification
On every cycle, the bound checker checks that SDA control moves only after a strobe. It also checks that arbitration loss releases SDA in the same cycle the flag rises, that the loss flag stays set until cleared, that bus START and STOP conditions set and clear `bus_busy`, and the reset values. The bench sweeps every byte value through write and read. For each value it checks MSB-first order, acknowledge sampling, and the acknowledge or withheld acknowledge on reads. The bench also runs a series of contending byte pairs, where the expected loss position is computed from the bits. Waiting for a free bus, the repeated START and STOP waveforms, and the behaviour after a loss can only be seen in these scenarios.

// File: rtl/i2c_eng_pkg.sv
`timescale 1ns/1ps
// Shared types for the I2C byte engine: command codes and sequencer states.
package i2c_eng_pkg;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_STOP   = 3'd1,
        OP_RSTART = 3'd2,
        OP_WRITE  = 3'd3,
        OP_READ   = 3'd4
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_STOP_LO,
        ST_STOP_HI,
        ST_RS_LO,
        ST_RS_HI,
        ST_BIT,
        ST_ACK
    } state_e;

endpackage

// File: rtl/i2c_bus_monitor.sv
`timescale 1ns/1ps
// Bus monitor: watches the sampled SCL/SDA levels for START and STOP
// conditions from any master and keeps a bus-busy flag.
// Assumes scl_in/sda_in are already synchronised to clk.
module i2c_bus_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic bus_busy,
    output logic start_seen,
    output logic stop_seen
);
    logic scl_q;
    logic sda_q;

    // Condition decode: SDA edge while SCL held high on both samples
    always_comb begin
        start_seen = scl_q & scl_in & sda_q & ~sda_in;
        stop_seen  = scl_q & scl_in & ~sda_q & sda_in;
    end

    // Previous-sample registers and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            bus_busy <= 1'b0;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
            if (start_seen)
                bus_busy <= 1'b1;
            else if (stop_seen)
                bus_busy <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_shift_unit.sv
`timescale 1ns/1ps
// Byte shift register: presents the MSB for transmission and shifts the
// sampled bus bit in at the LSB, counting the bits of one byte.
// Assumes load and shift are never asserted together.
module i2c_shift_unit #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              shift,
    input  logic              bit_in,
    output logic              msb,
    output logic              last,
    output logic [DATA_W-1:0] value
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0] cnt;

    // Outputs derived from the register contents
    always_comb begin
        msb  = value[DATA_W-1];
        last = (cnt == CNT_LAST);
    end

    // Shift register and bit counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
            cnt   <= '0;
        end else if (load) begin
            value <= load_val;
            cnt   <= '0;
        end else if (shift) begin
            value <= {value[DATA_W-2:0], bit_in};
            cnt   <= last ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c_arb_check.sv
`timescale 1ns/1ps
// Arbitration checker: flags a loss when the engine released SDA on a
// transmitted bit but the bus reads low; keeps a sticky flag until cleared.
// Assumes check is a one-cycle qualifier at the SCL-high sample point.
module i2c_arb_check (
    input  logic clk,
    input  logic rst_n,
    input  logic check,
    input  logic released,
    input  logic sda_in,
    input  logic clr,
    output logic lose_now,
    output logic lost_flag
);
    // Loss decode at the sample point
    always_comb lose_now = check & released & ~sda_in;

    // Sticky loss flag; a new loss wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            lost_flag <= 1'b0;
        else if (lose_now)
            lost_flag <= 1'b1;
        else if (clr)
            lost_flag <= 1'b0;
    end
endmodule

// File: rtl/i2c_byte_engine.sv
`timescale 1ns/1ps
// I2C byte engine (top): sequences START, STOP, repeated START, byte write
// and byte read with acknowledge on the ninth pulse, on an open-drain SDA.
// Assumes an external unit generates SCL and provides stb_low (mid SCL low)
// and stb_high (mid SCL high) strobes, one cycle each, while scl_req is high.
module i2c_byte_engine #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_drive_low,
    input  logic              stb_low,
    input  logic              stb_high,
    output logic              scl_req,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              cmd_ack,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rx_data,
    output logic              ack_rcvd,
    output logic              arb_lost,
    input  logic              arb_clr,
    output logic              bus_busy
);
    import i2c_eng_pkg::*;

    state_e state;
    logic   drive_q;
    logic   done_q;
    logic   ack_q;
    logic   is_write;
    logic   ack_en_q;
    op_e    op;

    logic              sh_load;
    logic              sh_shift;
    logic              sh_msb;
    logic              sh_last;
    logic [DATA_W-1:0] sh_value;
    logic              arb_check;
    logic              lose_now;
    logic              start_seen;
    logic              stop_seen;

    // Command decode and datapath controls
    always_comb begin
        op        = op_e'(cmd_op);
        sh_load   = (state == ST_IDLE) && cmd_valid &&
                    ((op == OP_WRITE) || (op == OP_READ));
        arb_check = (state == ST_BIT) && is_write && stb_high;
        sh_shift  = (state == ST_BIT) && stb_high && !lose_now;
    end

    i2c_bus_monitor u_mon (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .bus_busy   (bus_busy),
        .start_seen (start_seen),
        .stop_seen  (stop_seen)
    );

    i2c_shift_unit #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (sh_load),
        .load_val ((op == OP_WRITE) ? cmd_data : {DATA_W{1'b1}}),
        .shift    (sh_shift),
        .bit_in   (sda_in),
        .msb      (sh_msb),
        .last     (sh_last),
        .value    (sh_value)
    );

    i2c_arb_check u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .check     (arb_check),
        .released  (~drive_q),
        .sda_in    (sda_in),
        .clr       (arb_clr),
        .lose_now  (lose_now),
        .lost_flag (arb_lost)
    );

    // Command sequencer: owns the SDA drive register and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            drive_q  <= 1'b0;
            done_q   <= 1'b0;
            ack_q    <= 1'b0;
            is_write <= 1'b0;
            ack_en_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        case (op)
                            OP_START:  state <= ST_START;
                            OP_STOP:   state <= ST_STOP_LO;
                            OP_RSTART: state <= ST_RS_LO;
                            OP_WRITE: begin
                                state    <= ST_BIT;
                                is_write <= 1'b1;
                            end
                            OP_READ: begin
                                state    <= ST_BIT;
                                is_write <= 1'b0;
                                ack_en_q <= cmd_ack;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_START: begin
                    if (stb_high && !bus_busy) begin
                        drive_q <= 1'b1;
                        done_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_STOP_LO: begin
                    if (stb_low) begin
                        drive_q <= 1'b1;
                        state   <= ST_STOP_HI;
                    end
                end
                ST_STOP_HI: begin
                    if (stb_high) begin
                        drive_q <= 1'b0;
                        done_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_RS_LO: begin
                    if (stb_low) begin
                        drive_q <= 1'b0;
                        state   <= ST_RS_HI;
                    end
                end
                ST_RS_HI: begin
                    if (stb_high) begin
                        drive_q <= 1'b1;
                        done_q  <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_BIT: begin
                    if (stb_low) begin
                        drive_q <= is_write ? ~sh_msb : 1'b0;
                    end else if (stb_high) begin
                        if (lose_now) begin
                            drive_q <= 1'b0;
                            done_q  <= 1'b1;
                            state   <= ST_IDLE;
                        end else if (sh_last) begin
                            state <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (stb_low) begin
                        drive_q <= is_write ? 1'b0 : ack_en_q;
                    end else if (stb_high) begin
                        ack_q  <= is_write ? ~sda_in : 1'b0;
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port assignments
    always_comb begin
        sda_drive_low = drive_q;
        done          = done_q;
        ack_rcvd      = ack_q;
        rx_data       = sh_value;
        busy          = (state != ST_IDLE);
        scl_req       = (state != ST_IDLE) && (state != ST_START);
    end
endmodule

// File: rtl/i2c_byte_engine_chk.sv
`timescale 1ns/1ps
// Checker for the I2C byte engine; attached to every instance by bind.
module i2c_byte_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic sda_in,
    input logic sda_drive_low,
    input logic stb_low,
    input logic stb_high,
    input logic busy,
    input logic done,
    input logic arb_lost,
    input logic arb_clr,
    input logic bus_busy
);
    // R1: state after a reset cycle
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (!sda_drive_low && !busy && !done && !arb_lost && !bus_busy));

    // R2: SDA control moves only after a strobe
    assert_drive_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_drive_low) |-> ($past(stb_low) || $past(stb_high)));

    // R9: a loss releases SDA and finishes the command
    assert_arb_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> (!sda_drive_low && done && !busy));

    // R10: loss flag is sticky until cleared
    assert_arb_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !arb_clr) |=> arb_lost);

    // R11: START on the bus sets busy
    assert_bus_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in) && $past(sda_in) && !sda_in) |=> bus_busy);

    // R11: STOP on the bus clears busy
    assert_bus_stop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in) && !$past(sda_in) && sda_in) |=> !bus_busy);
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_in        (scl_in),
    .sda_in        (sda_in),
    .sda_drive_low (sda_drive_low),
    .stb_low       (stb_low),
    .stb_high      (stb_high),
    .busy          (busy),
    .done          (done),
    .arb_lost      (arb_lost),
    .arb_clr       (arb_clr),
    .bus_busy      (bus_busy)
);

// File: tb/i2c_byte_engine_tb.sv
`timescale 1ns/1ps
// Bench: plays SCL timing unit, slave and competing master on a wired-AND SDA.
module i2c_byte_engine_tb;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic tb_low = 1'b0;
    logic stb_low = 1'b0;
    logic stb_high = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [DW-1:0] cmd_data = '0;
    logic cmd_ack = 1'b0;
    logic arb_clr = 1'b0;
    logic dut_low, scl_req, busy, done, ack_rcvd, arb_lost, bus_busy;
    logic [DW-1:0] rx_data;
    logic sda_bus;
    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    assign sda_bus = ~(dut_low | tb_low);

    always #2.5 clk = ~clk;

    i2c_byte_engine #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_bus),
        .sda_drive_low(dut_low), .stb_low(stb_low), .stb_high(stb_high),
        .scl_req(scl_req), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_data(cmd_data), .cmd_ack(cmd_ack), .busy(busy), .done(done),
        .rx_data(rx_data), .ack_rcvd(ack_rcvd), .arb_lost(arb_lost),
        .arb_clr(arb_clr), .bus_busy(bus_busy)
    );

    task automatic check(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send_cmd(input logic [2:0] op, input logic [DW-1:0] d, input logic a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_data = d; cmd_ack = a;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // SCL low phase with a strobe; returns DUT drive after the strobe
    task automatic low_phase(input logic other_low, output logic drv_after);
        scl = 1'b0;
        @(negedge clk); tb_low = other_low;
        @(negedge clk); stb_low = 1'b1;
        @(negedge clk); stb_low = 1'b0; drv_after = dut_low;
        @(negedge clk);
    endtask

    // SCL high phase with a strobe; returns drive before and after, and done
    task automatic high_phase(output logic drv_before, output logic drv_after,
                              output logic done_seen);
        scl = 1'b1;
        @(negedge clk);
        @(negedge clk); drv_before = dut_low; stb_high = 1'b1;
        @(negedge clk); stb_high = 1'b0; drv_after = dut_low; done_seen = done;
        @(negedge clk);
    endtask

    // Full clock pulse: other devices drive other_low
    task automatic pulse(input logic other_low, output logic drv_hi,
                         output logic drv_after, output logic done_seen);
        logic d0;
        low_phase(other_low, d0);
        high_phase(drv_hi, drv_after, done_seen);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic dh, da, dn, d0;
        logic [DW-1:0] got;
        logic any_drive;
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 drive", dut_low, 0);
        check("R1 busy", busy, 0);
        check("R1 arb", arb_lost, 0);
        check("R1 bus_busy", bus_busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", done, 0);

        // R6: START on a free bus
        send_cmd(3'd0, '0, 1'b0);
        check("R6 busy", busy, 1);
        high_phase(dh, da, dn);
        check("R6 start drive", da, 1);
        check("R6 start done", dn, 1);
        check("R11 busy after start", bus_busy, 1);

        // R2/R3: every byte value written, slave acknowledges per pattern
        for (int v = 0; v < 256; v++) begin
            logic ackv;
            ackv = (v % 3) != 0;
            send_cmd(3'd3, DW'(v), 1'b0);
            got = '0;
            for (int i = 0; i < DW; i++) begin
                pulse(1'b0, dh, da, dn);
                got = {got[DW-2:0], ~dh};
            end
            check("R2 msb-first bits", got, v);
            pulse(ackv, dh, da, dn);
            tb_low = 1'b0;
            check("R3 released on ack pulse", dh, 0);
            check("R3 ack_rcvd", ack_rcvd, ackv);
            check("R3 done", dn, 1);
        end

        // R4/R5: every byte value read, acknowledge choice alternates
        for (int v = 0; v < 256; v++) begin
            logic ae;
            ae = v[0];
            send_cmd(3'd4, '0, ae);
            any_drive = 1'b0;
            for (int i = 0; i < DW; i++) begin
                pulse(~v[DW-1-i], dh, da, dn);
                any_drive = any_drive | dh;
            end
            pulse(1'b0, dh, da, dn);
            check("R4 released during read", any_drive, 0);
            check("R4 rx_data", rx_data, v);
            check("R5 ack drive", dh, ae);
        end

        // R8: repeated START
        send_cmd(3'd2, '0, 1'b0);
        low_phase(1'b0, d0);
        check("R8 release at low", d0, 0);
        high_phase(dh, da, dn);
        check("R8 drive low at high", da, 1);
        check("R8 done", dn, 1);
        @(negedge clk);
        check("R8 bus stays busy", bus_busy, 1);

        // R7: STOP
        send_cmd(3'd1, '0, 1'b0);
        low_phase(1'b0, d0);
        check("R7 drive low at low", d0, 1);
        high_phase(dh, da, dn);
        check("R7 release at high", da, 0);
        check("R7 done", dn, 1);
        check("R11 bus free after stop", bus_busy, 0);

        // R6: START held while another master owns the bus
        @(negedge clk); tb_low = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R11 other start seen", bus_busy, 1);
        send_cmd(3'd0, '0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            high_phase(dh, da, dn);
            check("R6 waits on busy bus", da, 0);
        end
        scl = 1'b0; @(negedge clk); @(negedge clk);
        scl = 1'b1; @(negedge clk); @(negedge clk);
        tb_low = 1'b0; @(negedge clk); @(negedge clk);
        check("R11 other stop seen", bus_busy, 0);
        high_phase(dh, da, dn);
        check("R6 start after free", da, 1);
        check("R6 done after free", dn, 1);

        // R9/R10: arbitration against a competing master
        for (int k = 0; k < 64; k++) begin
            logic [DW-1:0] a, b;
            int lose_at;
            bit lost;
            a = DW'((k * 37 + 11) & 255);
            b = DW'((k * 53 + 200) & 255);
            lose_at = -1;
            for (int i = DW - 1; i >= 0; i--)
                if (lose_at < 0 && a[i] && !b[i]) lose_at = DW - 1 - i;
            send_cmd(3'd3, a, 1'b0);
            lost = 0;
            for (int i = 0; i < DW; i++) begin
                pulse(~b[DW-1-i], dh, da, dn);
                if (lost) begin
                    check("R9 silent after loss", dh, 0);
                end else if (i == lose_at) begin
                    check("R9 release on loss", da, 0);
                    check("R9 flag on loss", arb_lost, 1);
                    check("R9 done on loss", dn, 1);
                    check("R9 idle on loss", busy, 0);
                    lost = 1;
                end
            end
            pulse(1'b0, dh, da, dn);
            tb_low = 1'b0;
            if (lose_at < 0) begin
                check("R9 no loss", arb_lost, 0);
                check("R9 byte completes", dn, 1);
            end else begin
                check("R10 sticky", arb_lost, 1);
                @(negedge clk); arb_clr = 1'b1;
                @(negedge clk); arb_clr = 1'b0;
                check("R10 cleared", arb_lost, 0);
            end
        end

        send_cmd(3'd1, '0, 1'b0);
        low_phase(1'b0, d0);
        high_phase(dh, da, dn);
        check("R7 final stop", da, 0);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule